// File: doc/BRIEF.md
# DRAM Command Mode Injector

This block sits between a simple host access port and a DRAM command bus. Software uses it to walk a memory device through its power-up and configuration sequence by hand. A mode value, written through a small register port, selects what the next host access turns into. In normal mode a host access is decoded as an ordinary read or write: a row activate followed by a column command. In any other mode the access becomes one fixed DRAM command, whatever its direction.

A newly written mode does not take effect at once. It is armed, and the first host write after it promotes it to the active mode. Host reads in between still use the previously active mode. The block keeps a flag recording that all banks are precharged. An auto-refresh request made while that flag is clear is not issued: it is dropped and a sticky error flag is raised instead.

The host address is split, from most to least significant, into bank, row and column fields. Command codes on `cmd_o` are: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge all, 5 load mode register, 6 auto-refresh, 7 extended load mode register, 8 deep power-down, 9 low-power mode register write.

Top module: `dram_mode_inject`

## Requirements
- R1: After reset `cmd_o` is NOP (0), `cmd_bank_o` and `cmd_addr_o` are zero, `host_ack_o`, `pchg_all_o` and `err_o` are low, and the active mode is normal.
- R2: In normal mode an accepted access drives activate (1) with the host bank and row in the cycle after acceptance. In the next cycle it drives read (2) when `host_we_i` was 0, or write (3) when it was 1, with the same bank, the column zero-extended on `cmd_addr_o`, and `host_ack_o` high.
- R3: The mode field is `cfg_wdata_i[2:0]`: 0 normal, 1 NOP, 2 precharge all, 3 load mode register, 4 auto-refresh, 5 extended load mode register, 6 deep power-down, 7 low-power mode register write. In any mode other than 0, an accepted access of either direction drives the mapped command for one cycle, in the cycle after acceptance, together with `host_ack_o`.
- R4: A mode written through `cfg_we_i` becomes active only at the next accepted host write, and that write already uses it. Host reads before that write use the previously active mode.
- R5: Auto-refresh (6) is driven only while `pchg_all_o` is high. An auto-refresh request made while it is low drives NOP, is still acknowledged, and sets `err_o`.
- R6: `pchg_all_o` goes high the cycle after precharge all (4) is driven, and low the cycle after activate (1) is driven. Reset clears it.
- R7: Load mode register drives bank 0 and the host row on `cmd_addr_o`. Extended load mode register drives the host bank field on `cmd_bank_o` and the host row on `cmd_addr_o`.
- R8: Low-power mode register write drives on `cmd_addr_o[7:0]` the select value captured from `cfg_wdata_i[15:8]` at the last register write, with the upper address bits and the bank zero.
- R9: When no command is issued, `cmd_o` is NOP. Every acknowledge lasts one cycle, and no request is accepted in a cycle in which `host_ack_o` is high.
- R10: `err_o` stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 16 | Mode in [2:0], mode register select in [15:8] |
| host_req_i | input | 1 | Host access request, held until acknowledged |
| host_we_i | input | 1 | Host access direction, 1 = write |
| host_addr_i | input | BANK_W+ROW_W+COL_W | Host address {bank, row, column} |
| host_ack_o | output | 1 | One-cycle acknowledge of a host access |
| cmd_o | output | 4 | DRAM command code |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_addr_o | output | ROW_W | Command address |
| pchg_all_o | output | 1 | All banks known to be precharged |
| err_o | output | 1 | Sticky refresh-ordering error |

## Verification
A wrong active or armed mode shows up at the ports in the cycle after the very next accepted access, as a wrong command code. A read issued while a mode is armed is the quickest way to tell the two registers apart. A stale or wrong precharge flag is exposed on `pchg_all_o` one cycle after activate or precharge all. It also shows up at the next auto-refresh request, as a refresh where a NOP is due or the reverse, together with a change in `err_o`. A lost column phase or a doubled acknowledge breaks the fixed activate-then-column shape, and the reference model compares that shape on every clock.

// File: rtl/dmi_pkg.sv
package dmi_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PREA = 4'd4,
    CMD_LMR  = 4'd5,
    CMD_REF  = 4'd6,
    CMD_EMRS = 4'd7,
    CMD_DPD  = 4'd8,
    CMD_MRW  = 4'd9
  } dmi_cmd_e;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_NOP    = 3'd1,
    MODE_PREA   = 3'd2,
    MODE_LMR    = 3'd3,
    MODE_REF    = 3'd4,
    MODE_EMRS   = 3'd5,
    MODE_DPD    = 3'd6,
    MODE_MRW    = 3'd7
  } dmi_mode_e;
endpackage

// File: rtl/dmi_mode_ctrl.sv
module dmi_mode_ctrl
  import dmi_pkg::*;
#(
  parameter int CFG_W = 16,
  parameter int SEL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             accept_i,
  input  logic             acc_we_i,
  output dmi_mode_e        eff_mode_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam int SEL_LSB = CFG_W - SEL_W;

  dmi_mode_e        pend_q, act_q;
  logic             pend_v_q;
  logic [SEL_W-1:0] sel_q;
  logic             promote;

  // armed mode is promoted by, and already applies to, the next host write
  assign promote    = acc_we_i && pend_v_q;
  assign eff_mode_o = promote ? pend_q : act_q;
  assign sel_o      = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= MODE_NORMAL;
      act_q    <= MODE_NORMAL;
      pend_v_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      if (accept_i && promote) begin
        act_q    <= pend_q;
        pend_v_q <= 1'b0;
      end
      if (cfg_we_i) begin
        pend_q   <= dmi_mode_e'(cfg_wdata_i[2:0]);
        pend_v_q <= 1'b1;
        sel_q    <= cfg_wdata_i[SEL_LSB +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/dmi_pchg_track.sv
module dmi_pchg_track
  import dmi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  dmi_cmd_e cmd_i,
  output logic     pchg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pchg_o <= 1'b0;
    else if (cmd_i == CMD_PREA) pchg_o <= 1'b1;
    else if (cmd_i == CMD_ACT)  pchg_o <= 1'b0;
  end
endmodule

// File: rtl/dmi_cmd_seq.sv
module dmi_cmd_seq
  import dmi_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int SEL_W  = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0] addr_i,
  input  dmi_mode_e                     mode_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic                          pchg_i,
  output logic                          accept_o,
  output dmi_cmd_e                      cmd_o,
  output logic [BANK_W-1:0]             bank_o,
  output logic [ROW_W-1:0]              addr_o,
  output logic                          ack_o,
  output logic                          err_o
);
  localparam int ROW_LSB  = COL_W;
  localparam int BANK_LSB = COL_W + ROW_W;

  logic [BANK_W-1:0] h_bank;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;
  logic              col_q, we_q;
  logic [BANK_W-1:0] sv_bank_q;
  logic [COL_W-1:0]  sv_col_q;

  dmi_cmd_e          n_cmd;
  logic [BANK_W-1:0] n_bank;
  logic [ROW_W-1:0]  n_addr;
  logic              n_ack, n_col, n_err;

  assign h_bank   = addr_i[BANK_LSB +: BANK_W];
  assign h_row    = addr_i[ROW_LSB +: ROW_W];
  assign h_col    = addr_i[0 +: COL_W];
  assign accept_o = req_i && !ack_o && !col_q;

  always_comb begin
    n_cmd  = CMD_NOP;
    n_bank = '0;
    n_addr = '0;
    n_ack  = 1'b0;
    n_col  = 1'b0;
    n_err  = err_o;
    if (col_q) begin
      n_cmd  = we_q ? CMD_WR : CMD_RD;
      n_bank = sv_bank_q;
      n_addr[COL_W-1:0] = sv_col_q;
      n_ack  = 1'b1;
    end else if (accept_o) begin
      n_ack = 1'b1;
      unique case (mode_i)
        MODE_NORMAL: begin
          n_cmd  = CMD_ACT;
          n_bank = h_bank;
          n_addr = h_row;
          n_ack  = 1'b0;
          n_col  = 1'b1;
        end
        MODE_NOP:  n_cmd = CMD_NOP;
        MODE_PREA: n_cmd = CMD_PREA;
        MODE_LMR: begin
          n_cmd  = CMD_LMR;
          n_addr = h_row;
        end
        MODE_REF: begin
          if (pchg_i) n_cmd = CMD_REF;
          else        n_err = 1'b1;
        end
        MODE_EMRS: begin
          n_cmd  = CMD_EMRS;
          n_bank = h_bank;
          n_addr = h_row;
        end
        MODE_DPD: n_cmd = CMD_DPD;
        MODE_MRW: begin
          n_cmd = CMD_MRW;
          n_addr[SEL_W-1:0] = sel_i;
        end
        default: n_cmd = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= CMD_NOP;
      bank_o    <= '0;
      addr_o    <= '0;
      ack_o     <= 1'b0;
      err_o     <= 1'b0;
      col_q     <= 1'b0;
      we_q      <= 1'b0;
      sv_bank_q <= '0;
      sv_col_q  <= '0;
    end else begin
      cmd_o  <= n_cmd;
      bank_o <= n_bank;
      addr_o <= n_addr;
      ack_o  <= n_ack;
      err_o  <= n_err;
      col_q  <= n_col;
      if (accept_o) begin
        we_q      <= we_i;
        sv_bank_q <= h_bank;
        sv_col_q  <= h_col;
      end
    end
  end
endmodule

// File: rtl/dram_mode_inject.sv
module dram_mode_inject
  import dmi_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int CFG_W  = 16,
  parameter int SEL_W  = 8,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic              host_ack_o,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_addr_o,
  output logic              pchg_all_o,
  output logic              err_o
);
  dmi_mode_e        eff_mode;
  logic [SEL_W-1:0] sel;
  logic             accept;
  dmi_cmd_e         cmd;

  assign cmd_o = cmd;

  dmi_mode_ctrl #(.CFG_W(CFG_W), .SEL_W(SEL_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .accept_i   (accept),
    .acc_we_i   (host_we_i),
    .eff_mode_o (eff_mode),
    .sel_o      (sel)
  );

  dmi_cmd_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .SEL_W(SEL_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (host_req_i),
    .we_i    (host_we_i),
    .addr_i  (host_addr_i),
    .mode_i  (eff_mode),
    .sel_i   (sel),
    .pchg_i  (pchg_all_o),
    .accept_o(accept),
    .cmd_o   (cmd),
    .bank_o  (cmd_bank_o),
    .addr_o  (cmd_addr_o),
    .ack_o   (host_ack_o),
    .err_o   (err_o)
  );

  dmi_pchg_track u_track (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd),
    .pchg_o(pchg_all_o)
  );
endmodule

// File: rtl/dmi_checker.sv
module dmi_checker #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int SEL_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_ack_o,
  input logic [3:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [ROW_W-1:0]  cmd_addr_o,
  input logic              pchg_all_o,
  input logic              err_o
);
  localparam logic [3:0] C_NOP = 4'd0, C_ACT = 4'd1, C_RD = 4'd2, C_WR = 4'd3,
                         C_PREA = 4'd4, C_LMR = 4'd5, C_REF = 4'd6, C_MRW = 4'd9;

  assert_act_then_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_ACT |=> (cmd_o == C_RD || cmd_o == C_WR) && host_ack_o);
  assert_ack_not_act_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |-> cmd_o != C_ACT);
  assert_ref_needs_pchg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_REF |-> pchg_all_o);
  assert_act_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_ACT |=> !pchg_all_o);
  assert_prea_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_PREA |=> pchg_all_o);
  assert_lmr_bank_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_LMR |-> cmd_bank_o == '0);
  assert_mrw_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == C_MRW |-> cmd_addr_o[ROW_W-1:SEL_W] == '0);
  assert_ack_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |=> !host_ack_o);
  assert_cmd_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != C_NOP && cmd_o != C_ACT) |=> cmd_o == C_NOP);
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind dram_mode_inject dmi_checker #(.BANK_W(BANK_W), .ROW_W(ROW_W), .SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .host_ack_o(host_ack_o),
  .cmd_o     (cmd_o),
  .cmd_bank_o(cmd_bank_o),
  .cmd_addr_o(cmd_addr_o),
  .pchg_all_o(pchg_all_o),
  .err_o     (err_o)
);

// File: tb/tb_dram_mode_inject.sv
module tb_dram_mode_inject;
  localparam int BW = 3, RW = 14, CW = 10, AW = BW + RW + CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, req = 1'b0, we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [AW-1:0] addr = '0;
  logic ack, pchg, err;
  logic [3:0] cmd;
  logic [BW-1:0] cbank;
  logic [RW-1:0] caddr;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  dram_mode_inject dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .host_req_i(req), .host_we_i(we), .host_addr_i(addr), .host_ack_o(ack),
    .cmd_o(cmd), .cmd_bank_o(cbank), .cmd_addr_o(caddr), .pchg_all_o(pchg), .err_o(err)
  );

  // behavioural reference model
  int e_cmd, e_bank, e_addr, e_ack, e_pchg, e_err;
  int m_act, m_pend, m_pend_v, m_sel, m_col, m_we, m_bank, m_c;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_cmd = 0; e_bank = 0; e_addr = 0; e_ack = 0; e_pchg = 0; e_err = 0;
      m_act = 0; m_pend = 0; m_pend_v = 0; m_sel = 0; m_col = 0; m_we = 0; m_bank = 0; m_c = 0;
    end else begin
      int np, ncmd, nbank, naddr, nack, md;
      np = e_pchg;
      if (e_cmd == 1) np = 0;
      if (e_cmd == 4) np = 1;
      ncmd = 0; nbank = 0; naddr = 0; nack = 0;
      if (m_col != 0) begin
        ncmd = m_we ? 3 : 2; nbank = m_bank; naddr = m_c; nack = 1; m_col = 0;
      end else if (req && e_ack == 0) begin
        md = m_act;
        if (we && m_pend_v != 0) begin md = m_pend; m_act = m_pend; m_pend_v = 0; end
        nack = 1;
        case (md)
          0: begin ncmd = 1; nbank = int'(addr[AW-1 -: BW]); naddr = int'(addr[CW +: RW]);
                   nack = 0; m_col = 1; m_we = we; m_bank = nbank; m_c = int'(addr[CW-1:0]); end
          1: ncmd = 0;
          2: ncmd = 4;
          3: begin ncmd = 5; naddr = int'(addr[CW +: RW]); end
          4: if (e_pchg != 0) ncmd = 6; else e_err = 1;
          5: begin ncmd = 7; nbank = int'(addr[AW-1 -: BW]); naddr = int'(addr[CW +: RW]); end
          6: ncmd = 8;
          default: begin ncmd = 9; naddr = m_sel; end
        endcase
      end
      if (cfg_we) begin m_pend = int'(cfg_wdata[2:0]); m_pend_v = 1; m_sel = int'(cfg_wdata[15:8]); end
      e_cmd = ncmd; e_bank = nbank; e_addr = naddr; e_ack = nack; e_pchg = np;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("cmd", int'(cmd), e_cmd);
    chk("bank", int'(cbank), e_bank);
    chk("addr", int'(caddr), e_addr);
    chk("ack", int'(ack), e_ack);
    chk("pchg", int'(pchg), e_pchg);
    chk("err", int'(err), e_err);
  end

  task automatic cfg(input int mode, input int sel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {sel[7:0], 5'd0, mode[2:0]};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit w, input int b, input int r, input int c);
    @(negedge clk);
    req = 1'b1; we = w; addr = {b[BW-1:0], r[RW-1:0], c[CW-1:0]};
    do @(negedge clk); while (!ack);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  initial begin
    tag = "R1";
    idle(2);
    rst_n = 1'b1;
    idle(2);
    tag = "R2";
    access(1'b0, 5, 16'h1234, 10'h3ff);
    access(1'b1, 2, 16'h0abc, 10'h011);
    idle(2);
    tag = "R5";                    // refresh with banks not precharged
    cfg(4, 0);
    access(1'b1, 0, 0, 0);
    tag = "R10";
    idle(3);
    tag = "R4";                    // armed precharge; read still uses refresh mode
    cfg(2, 0);
    access(1'b0, 0, 0, 0);
    access(1'b1, 0, 0, 0);
    tag = "R3";
    access(1'b0, 7, 5, 5);
    tag = "R6";
    idle(2);
    tag = "R5";
    cfg(4, 0);
    access(1'b1, 1, 2, 3);
    access(1'b0, 1, 2, 3);
    tag = "R7";
    cfg(3, 0);
    access(1'b1, 6, 16'h2aaa, 9);
    cfg(5, 0);
    access(1'b1, 3, 16'h1555, 1);
    access(1'b0, 4, 16'h0077, 1);
    tag = "R3";
    cfg(6, 0);
    access(1'b1, 0, 0, 0);
    cfg(1, 0);
    access(1'b0, 0, 0, 0);     // still deep power-down: armed NOP needs a write
    access(1'b1, 0, 0, 0);
    tag = "R8";
    cfg(7, 8'ha5);
    access(1'b1, 2, 3, 4);
    cfg(7, 8'h3c);
    access(1'b1, 2, 3, 4);
    tag = "R4";
    cfg(0, 0);
    access(1'b0, 1, 1, 1);     // still low-power mode register write
    tag = "R6";
    access(1'b1, 3, 16'h0100, 10'h020);
    tag = "R9";
    @(negedge clk); req = 1'b1; we = 1'b0; addr = '0;
    idle(6);                   // held request: accepted again only after each ack
    req = 1'b0;
    idle(3);
    tag = "R10";
    rst_n = 1'b0;
    idle(2);
    tag = "R1";
    rst_n = 1'b1;
    idle(3);
    summary();
  end
endmodule